// File: doc/BRIEF.md
# Command-Indexed Control Register Port

This block is a bus slave for an asynchronous microprocessor bus. It holds a bank of 8-bit control registers for a four-channel voice transcoder. Each channel has an encoder instance and a decoder instance. Access takes two phases. First a command write stores a register number. Later data reads and writes then reach the register that number picks. The host may run an 8-bit bus or a 4-bit bus. On a 4-bit bus only the lower four data pins carry information, and a nibble-select pin picks the upper or lower half of the addressed register.

The strobes, selects and data are resampled into the block clock through a two-flop synchroniser. A write takes effect on the rising edge of the synchronised write strobe. Command 1 is a set of self-clearing initialisation bits, one per encoder or decoder instance. Writing a 1 gives a one-cycle pulse on the matching output, and the register always reads back 0. Command 7 is a read-only view of the hardware silence flags, masked by the per-channel detection enables held in command 6. The active-low request pin is asserted whenever any enabled channel reports a flag.

Top module: `cmd_reg_port`

## Requirements
- R1: A write with chip select low, read strobe high and command/data select high loads the command number from din[3:0] on the rising edge of the write strobe. All later data accesses reach the register with that number.
- R2: On the 8-bit bus (bus_4bit low), a data write stores din into the current register, keeping only the implemented bits. Implemented bits by command: 2, 3, 4, 8, 11 and 12 use bits 7:0. Command 5 uses 2:0, command 6 uses 3:0, command 9 uses 4:0, command 10 uses 5:0, command 13 uses 3:0 and command 14 uses bit 0. Bits that are not implemented read 0.
- R3: On the 4-bit bus (bus_4bit high), a data write with hi_sel high puts din[3:0] into register bits 7:4, and with hi_sel low into bits 3:0. The other nibble is left unchanged. A read returns the selected nibble on dout[3:0] with dout[7:4] at 0.
- R4: While chip select and read strobe are low, write strobe is high and command/data select is low, dout shows the current register. Otherwise dout is 0, and this includes a read with command/data select high.
- R5: Writing a 1 to a bit of command 1 drives the matching init_pulse bit high for exactly one clock cycle. Command 1 reads back as 0.
- R6: Command 7 reads {4'b0, det_flag_in & det_en}, with det_flag_in registered once. A write to command 7 changes no register.
- R7: srq_n is low while any bit of det_flag_in & det_en is set, and high otherwise.
- R8: Commands 0 and 15 store nothing and read 0.
- R9: A write strobe while chip select is high changes no register. Register outputs change only on a committed write.
- R10: After reset every register is 0, the command is 0, dout is 0 and srq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_4bit | input | 1 | High selects the 4-bit bus |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd_sel | input | 1 | High: command access; low: register data |
| hi_sel | input | 1 | Nibble select for the 4-bit bus |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host, 0 when not reading |
| det_flag_in | input | 4 | Per-channel silence flags from detectors |
| srq_n | output | 1 | Service request, active low |
| init_pulse | output | 8 | One-cycle initialisation pulses (command 1) |
| pwr_dn | output | 8 | Per-instance power down (command 2) |
| mute | output | 8 | Per-instance mute (command 3) |
| noise_en | output | 8 | Background noise enables (command 4) |
| noise_lvl | output | 3 | Noise level (command 5) |
| det_en | output | 4 | Silence detection enables (command 6) |
| det_level | output | 13 | Detection threshold {cmd 9[4:0], cmd 8} |
| det_time | output | 6 | Detection time (command 10) |
| att_lvl | output | 8 | 2-bit attenuation per channel (command 11) |
| thru | output | 8 | Per-instance through mode (command 12) |
| loopback | output | 4 | Per-channel loopback (command 13) |
| sync_mode | output | 1 | Global serial timing mode (command 14) |

## Verification
Some properties are checked on every cycle. The initialisation pulses last a single cycle. The request pin stays high while no channel is enabled, and its low state implies at least one enable. The upper nibble of dout is zero on the 4-bit bus, and dout is zero when no read strobe is present. The control outputs stay constant while the write strobe stays high. Other behaviour can only be shown by the bench's scenarios. These are the per-command bit masks, the nibble merging, the two-phase command selection, the ignored writes to the flag register and to a deselected chip, and the read-back of masked flags.

// File: rtl/cmd_reg_port.sv
module cmd_reg_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_4bit,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        cd_sel,
  input  logic        hi_sel,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  input  logic [3:0]  det_flag_in,
  output logic        srq_n,
  output logic [7:0]  init_pulse,
  output logic [7:0]  pwr_dn,
  output logic [7:0]  mute,
  output logic [7:0]  noise_en,
  output logic [2:0]  noise_lvl,
  output logic [3:0]  det_en,
  output logic [12:0] det_level,
  output logic [5:0]  det_time,
  output logic [7:0]  att_lvl,
  output logic [7:0]  thru,
  output logic [3:0]  loopback,
  output logic        sync_mode
);
  localparam int BW = 13;
  localparam logic [BW-1:0] IDLE = 13'h1C00;
  localparam int NREG = 16;

  logic [BW-1:0] sq [SYNC_STAGES+1];
  logic [BW-1:0] cur, prv;
  logic [7:0]    rf [NREG];
  logic [3:0]    cmd_q;
  logic [3:0]    flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= SYNC_STAGES; i++) sq[i] <= IDLE;
    end else begin
      sq[0] <= {cs_n, rd_n, wr_n, cd_sel, hi_sel, din};
      for (int i = 1; i <= SYNC_STAGES; i++) sq[i] <= sq[i-1];
    end
  end

  assign cur = sq[SYNC_STAGES-1];
  assign prv = sq[SYNC_STAGES];

  function automatic logic [7:0] wmask(input logic [3:0] c);
    case (c)
      4'd2, 4'd3, 4'd4, 4'd8, 4'd11, 4'd12: wmask = 8'hFF;
      4'd5:  wmask = 8'h07;
      4'd6:  wmask = 8'h0F;
      4'd9:  wmask = 8'h1F;
      4'd10: wmask = 8'h3F;
      4'd13: wmask = 8'h0F;
      4'd14: wmask = 8'h01;
      default: wmask = 8'h00;
    endcase
  endfunction

  wire       commit = !prv[12] && prv[11] && !prv[10] && cur[10];
  wire       cmd_wr = commit && prv[9];
  wire       dat_wr = commit && !prv[9];
  wire [7:0] lanes  = bus_4bit ? (prv[8] ? 8'hF0 : 8'h0F) : 8'hFF;
  wire [7:0] wword  = bus_4bit ? {prv[3:0], prv[3:0]} : prv[7:0];
  wire [7:0] wmsk   = wmask(cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      cmd_q      <= '0;
      init_pulse <= '0;
      flg_q      <= '0;
    end else begin
      flg_q      <= det_flag_in;
      init_pulse <= (dat_wr && cmd_q == 4'd1) ? (wword & lanes) : '0;
      if (cmd_wr) cmd_q <= prv[3:0];
      if (dat_wr)
        rf[cmd_q] <= ((rf[cmd_q] & ~lanes) | (wword & lanes)) & wmsk;
    end
  end

  wire [3:0] flg_act = flg_q & rf[6][3:0];
  wire       rd_act  = !cur[12] && !cur[11] && cur[10] && !cur[9];
  wire [7:0] rval    = (cmd_q == 4'd7) ? {4'b0, flg_act} : rf[cmd_q];
  wire [7:0] rsel    = bus_4bit ? {4'b0, cur[8] ? rval[7:4] : rval[3:0]} : rval;

  assign dout      = rd_act ? rsel : 8'h00;
  assign srq_n     = ~|flg_act;
  assign pwr_dn    = rf[2];
  assign mute      = rf[3];
  assign noise_en  = rf[4];
  assign noise_lvl = rf[5][2:0];
  assign det_en    = rf[6][3:0];
  assign det_level = {rf[9][4:0], rf[8]};
  assign det_time  = rf[10][5:0];
  assign att_lvl   = rf[11];
  assign thru      = rf[12];
  assign loopback  = rf[13][3:0];
  assign sync_mode = rf[14][0];
endmodule

// File: rtl/cmd_reg_port_chk.sv
module cmd_reg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_4bit,
  input logic        rd_n,
  input logic        wr_n,
  input logic [7:0]  dout,
  input logic        srq_n,
  input logic [7:0]  init_pulse,
  input logic [7:0]  pwr_dn,
  input logic [7:0]  mute,
  input logic [7:0]  noise_en,
  input logic [3:0]  det_en,
  input logic [7:0]  att_lvl,
  input logic [7:0]  thru
);
  a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|init_pulse) |=> (init_pulse == 8'h00));

  a_r7_no_enable_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en == 4'h0) |-> srq_n);

  a_r7_request_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !srq_n |-> (det_en != 4'h0));

  a_r3_upper_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_4bit |-> (dout[7:4] == 4'h0));

  a_r4_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && $past(rd_n) && $past(rd_n, 2)) |-> (dout == 8'h00));

  a_r9_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && $past(wr_n) && $past(wr_n, 2) && $past(wr_n, 3) && $past(wr_n, 4))
      |-> ($stable({pwr_dn, mute, noise_en, att_lvl, thru}) && init_pulse == 8'h00));
endmodule

bind cmd_reg_port cmd_reg_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_4bit(bus_4bit), .rd_n(rd_n), .wr_n(wr_n),
  .dout(dout), .srq_n(srq_n), .init_pulse(init_pulse), .pwr_dn(pwr_dn),
  .mute(mute), .noise_en(noise_en), .det_en(det_en), .att_lvl(att_lvl), .thru(thru)
);

// File: tb/test_cmd_reg_port.sv
`timescale 1ns/1ps
module test_cmd_reg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_4bit = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd_sel = 1'b0, hi_sel = 1'b0;
  logic [7:0] din = 8'h00;
  logic [3:0] det_flag_in = 4'h0;
  logic [7:0] dout, init_pulse, pwr_dn, mute, noise_en, att_lvl, thru;
  logic [2:0] noise_lvl;
  logic [3:0] det_en, loopback;
  logic [12:0] det_level;
  logic [5:0] det_time;
  logic srq_n, sync_mode;

  int checks = 0, errors = 0;
  int pl_cnt = 0;
  logic [7:0] pl_last = 8'h00;

  always #2.5 clk = ~clk;

  cmd_reg_port i_cmd_reg_port (
    .clk(clk), .rst_n(rst_n), .bus_4bit(bus_4bit), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .cd_sel(cd_sel), .hi_sel(hi_sel), .din(din), .dout(dout),
    .det_flag_in(det_flag_in), .srq_n(srq_n), .init_pulse(init_pulse),
    .pwr_dn(pwr_dn), .mute(mute), .noise_en(noise_en), .noise_lvl(noise_lvl),
    .det_en(det_en), .det_level(det_level), .det_time(det_time),
    .att_lvl(att_lvl), .thru(thru), .loopback(loopback), .sync_mode(sync_mode)
  );

  always @(negedge clk) if (init_pulse != 8'h00) begin
    pl_cnt++;
    pl_last = init_pulse;
  end

  // {command, write data, expected read-back} on the 8-bit bus
  localparam logic [19:0] VEC [14] = '{
    {4'd2,  8'hA5, 8'hA5}, {4'd3,  8'h3C, 8'h3C}, {4'd4,  8'hFF, 8'hFF},
    {4'd5,  8'hFF, 8'h07}, {4'd6,  8'hFE, 8'h0E}, {4'd8,  8'h81, 8'h81},
    {4'd9,  8'hFF, 8'h1F}, {4'd10, 8'hFF, 8'h3F}, {4'd11, 8'h6B, 8'h6B},
    {4'd12, 8'h5A, 8'h5A}, {4'd13, 8'hF3, 8'h03}, {4'd14, 8'hFF, 8'h01},
    {4'd0,  8'hFF, 8'h00}, {4'd15, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic cd, input logic hi, input logic [7:0] d, input logic cs);
    @(negedge clk);
    cd_sel = cd; hi_sel = hi; din = d; cs_n = cs;
    repeat (3) @(negedge clk);
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input logic cd, input logic hi, output logic [7:0] v);
    @(negedge clk);
    cd_sel = cd; hi_sel = hi; cs_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    v = dout;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int c0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 dout", dout, 8'h00);
    chk("R10 srq_n", srq_n, 1'b1);
    chk("R10 pwr_dn", pwr_dn, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(1'b0, 1'b0, v);
    chk("R10 cmd0 read", v, 8'h00);

    // R1 R2 R8 table walk
    for (int i = 0; i < 14; i++) begin
      bus_wr(1'b1, 1'b0, {4'h0, VEC[i][19:16]}, 1'b0);
      bus_wr(1'b0, 1'b0, VEC[i][15:8], 1'b0);
      bus_rd(1'b0, 1'b0, v);
      chk($sformatf("R2 cmd %0d readback", VEC[i][19:16]), v, VEC[i][7:0]);
    end
    chk("R2 pwr_dn port", pwr_dn, 8'hA5);
    chk("R2 det_level port", det_level, 13'h1F81);
    chk("R2 loopback port", loopback, 4'h3);
    chk("R2 sync_mode port", sync_mode, 1'b1);
    chk("R2 noise_lvl port", noise_lvl, 3'h7);

    // R4 read with command select high, and idle bus
    bus_rd(1'b1, 1'b0, v);
    chk("R4 read with cd high", v, 8'h00);
    chk("R4 idle dout", dout, 8'h00);

    // R1 re-select command 3, R9 write with cs high is ignored
    bus_wr(1'b1, 1'b0, 8'h03, 1'b0);
    bus_wr(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R9 mute after deselected write", mute, 8'h3C);
    bus_rd(1'b0, 1'b0, v);
    chk("R1 read reaches cmd 3", v, 8'h3C);

    // R3 nibble access
    bus_4bit = 1'b1;
    bus_wr(1'b1, 1'b1, 8'h02, 1'b0);
    bus_wr(1'b0, 1'b1, 8'hFC, 1'b0);
    chk("R3 upper nibble write", pwr_dn, 8'hC5);
    bus_rd(1'b0, 1'b0, v);
    chk("R3 low nibble read", v, 8'h05);
    bus_rd(1'b0, 1'b1, v);
    chk("R3 high nibble read", v, 8'h0C);
    bus_wr(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R3 lower nibble write", pwr_dn, 8'hC0);
    bus_4bit = 1'b0;

    // R5 self-clearing init bits
    bus_wr(1'b1, 1'b0, 8'h01, 1'b0);
    c0 = pl_cnt;
    bus_wr(1'b0, 1'b0, 8'h81, 1'b0);
    chk("R5 pulse cycles", pl_cnt - c0, 1);
    chk("R5 pulse bits", pl_last, 8'h81);
    bus_rd(1'b0, 1'b0, v);
    chk("R5 readback zero", v, 8'h00);

    // R6 R7 flags (det_en = 4'hE)
    det_flag_in = 4'b0001;
    repeat (3) @(negedge clk);
    chk("R7 disabled flag no request", srq_n, 1'b1);
    bus_wr(1'b1, 1'b0, 8'h07, 1'b0);
    bus_rd(1'b0, 1'b0, v);
    chk("R6 masked flag read", v, 8'h00);
    det_flag_in = 4'b0011;
    repeat (3) @(negedge clk);
    chk("R7 enabled flag request", srq_n, 1'b0);
    bus_rd(1'b0, 1'b0, v);
    chk("R6 flag read", v, 8'h02);
    bus_wr(1'b0, 1'b0, 8'hFF, 1'b0);
    bus_rd(1'b0, 1'b0, v);
    chk("R6 write to flags ignored", v, 8'h02);
    chk("R6 det_en untouched", det_en, 4'hE);
    det_flag_in = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R7 request released", srq_n, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule